// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of a serial peripheral link in front of a byte-wide nonvolatile store with an 18-bit byte address space. A free-running system clock samples the serial clock, data in, chip select, hold and write-protect pins through two-flop synchronizers. On each serial clock edge it advances a small command engine. The engine takes an 8-bit opcode and then runs one of seven sequences: set or clear the write-enable latch, read or write the status byte, stream bytes out of the array, stream bytes into the array, or return a fixed three-byte identifier.

Array transfers take a 24-bit address, of which only the low 18 bits count. The address then advances after every byte for as long as chip select stays low, and it wraps from the last byte back to byte zero. A separate protection unit decides whether a status write or an array write may go ahead. It bases that decision on the write-enable latch, two block-protect bits, a status-write-disable bit and the write-protect pin. The serial output is a registered data bit with a separate output enable that is active only while the engine is shifting data out. The array is an inferred RAM whose depth is a parameter, kept small by default, and is indexed by the low address bits.

Top module: `spi_mem_slave`

## Requirements
- R1: The opcodes are 0x06 (set write-enable), 0x04 (clear write-enable), 0x05 (status read), 0x01 (status write), 0x03 (array read), 0x02 (array write) and 0x9F (identifier read). While chip select is high, so_oe_o is 0, and it is also 0 during the opcode, the address and the write-data phases.
- R2: After any other opcode, the engine ignores every later bit and keeps so_oe_o at 0 until chip select rises. A new command is then accepted normally.
- R3: SI is taken on the rising serial clock edge and SO changes on the falling edge, most significant bit first. The engine works with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R4: An array read or write sends 24 address bits MSB first after the opcode. Only the low 18 bits are used. During a read, the address advances after each 8 data clocks.
- R5: After the address 0x3FFFF, both the read and the write burst continue at address 0x00000, with no length limit.
- R6: The identifier read returns 0xAE, then 0x83, then 0x1A. After the third byte, so_oe_o returns to 0.
- R7: The status byte reads bit 7 = write-disable (SRD), bits 3:2 = block protect, bit 1 = write-enable latch, and 0 in all other bits. Reset clears it. Opcode 0x06 sets the latch and 0x04 clears it. After an array-write or status-write command, the latch clears when chip select rises.
- R8: An array byte is written only when the latch is set and the address is outside the protected range. Block protect 00 protects nothing, 01 protects 0x30000 and up, 10 protects 0x20000 and up, and 11 protects everything.
- R9: A status write changes only bits 7, 3 and 2. It requires the latch to be set, and it is refused when SRD is 1 and the write-protect pin is low.
- R10: A write byte is stored only after all 8 bits have arrived. If chip select rises partway through a byte, that byte is discarded.
- R11: While hold is low, so_oe_o is 0 and the serial clock and SI are ignored. The transfer resumes where it stopped once hold returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data in |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Hold, active low |
| wpn_i | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |

## Verification
The bench writes a burst across the top of the address space. A design without the wrap would leave the byte after 0x3FFFF unwritten or reading back wrong. It cuts chip select after five bits of a write byte. A design that commits on a byte counter instead of on the eighth bit would corrupt the next address. It covers the boundary 0x2FF00/0x30005 under block protect 01, refused writes with the latch clear and with SRD set and the write-protect pin low, and the masking of unused status bits. Further cases are an unknown opcode followed by a set-write-enable byte, which must not take effect, a hold in the middle of a read byte, which must not shift the data out by the clocks sent during the hold, and the output enable after the third identifier byte.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_RST  = 8'h05;
  localparam logic [7:0] OP_WST  = 8'h01;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_WR   = 8'h02;
  localparam logic [7:0] OP_ID   = 8'h9F;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_WDATA, ST_RDATA, ST_WSR, ST_RSR, ST_RID, ST_DEAD
  } eng_st_e;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    id_byte = 8'hAE;
      2'd1:    id_byte = 8'h83;
      default: id_byte = 8'h1A;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_wprot.sv
module spi_wprot #(
  parameter int AW = 18
) (
  input  logic          wel_i,
  input  logic          srd_i,
  input  logic [1:0]    bp_i,
  input  logic          wpn_i,
  input  logic [AW-1:0] addr_i,
  output logic          arr_ok_o,
  output logic          sr_ok_o
);
  logic blocked;

  always_comb begin
    case (bp_i)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = (addr_i[AW-1:AW-2] == 2'b11);
      2'b10:   blocked = addr_i[AW-1];
      default: blocked = 1'b1;
    endcase
  end

  assign arr_ok_o = wel_i && !blocked;
  assign sr_ok_o  = wel_i && !(srd_i && !wpn_i);
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic si_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic wpn_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_RST = 5'b11100;

  logic [NPIN-1:0] pins_s;
  logic csn_s, holdn_s, wpn_s, sck_s, si_s, sck_d;
  logic rise, fall;

  spi_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({csn_i, holdn_i, wpn_i, sck_i, si_i}),
    .q_o(pins_s)
  );
  assign {csn_s, holdn_s, wpn_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end
  assign rise = sck_s && !sck_d;
  assign fall = !sck_s && sck_d;

  eng_st_e         state;
  logic [2:0]      bitcnt;
  logic [1:0]      acnt;
  logic [1:0]      idcnt;
  logic [7:0]      shreg;
  logic [7:0]      sh_next;
  logic [ADDR_W-1:0] addr;
  logic            wel_q, srd_q, clr_wel;
  logic [1:0]      bp_q;
  logic            so_q, oe_q;
  logic            arr_ok, sr_ok;
  logic            mem_we;
  logic [7:0]      mem_rdata;
  logic [7:0]      out_byte;
  logic            out_st;

  assign sh_next = {shreg[6:0], si_s};
  assign out_st  = (state == ST_RDATA) || (state == ST_RSR) || (state == ST_RID);

  spi_wprot #(.AW(ADDR_W)) u_prot (
    .wel_i(wel_q), .srd_i(srd_q), .bp_i(bp_q), .wpn_i(wpn_s),
    .addr_i(addr), .arr_ok_o(arr_ok), .sr_ok_o(sr_ok)
  );

  assign mem_we = !csn_s && holdn_s && rise && (state == ST_WDATA) &&
                  (bitcnt == 3'd7) && arr_ok;

  spi_mem_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we_i(mem_we), .waddr_i(addr[MEM_AW-1:0]), .wdata_i(sh_next),
    .raddr_i(addr[MEM_AW-1:0]), .rdata_o(mem_rdata)
  );

  always_comb begin
    case (state)
      ST_RSR:  out_byte = {srd_q, 3'b000, bp_q, wel_q, 1'b0};
      ST_RID:  out_byte = id_byte(idcnt);
      default: out_byte = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OP;
      bitcnt  <= '0;
      acnt    <= '0;
      idcnt   <= '0;
      shreg   <= '0;
      addr    <= '0;
      wel_q   <= 1'b0;
      srd_q   <= 1'b0;
      bp_q    <= 2'b00;
      clr_wel <= 1'b0;
      so_q    <= 1'b0;
    end else if (csn_s) begin
      state  <= ST_OP;
      bitcnt <= '0;
      acnt   <= '0;
      idcnt  <= '0;
      if (clr_wel) begin
        wel_q   <= 1'b0;
        clr_wel <= 1'b0;
      end
    end else if (holdn_s) begin
      if (rise) begin
        bitcnt <= bitcnt + 3'd1;
        shreg  <= sh_next;
        case (state)
          ST_OP: if (bitcnt == 3'd7) begin
            case (sh_next)
              OP_WEN:  begin wel_q <= 1'b1; state <= ST_DEAD; end
              OP_WDIS: begin wel_q <= 1'b0; state <= ST_DEAD; end
              OP_RST:  state <= ST_RSR;
              OP_WST:  begin state <= ST_WSR; clr_wel <= 1'b1; end
              OP_RD:   state <= ST_ADDR;
              OP_WR:   begin state <= ST_ADDR; clr_wel <= 1'b1; end
              OP_ID:   state <= ST_RID;
              default: state <= ST_DEAD;
            endcase
          end
          ST_ADDR: begin
            addr <= {addr[ADDR_W-2:0], si_s};
            if (bitcnt == 3'd7) begin
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) state <= clr_wel ? ST_WDATA : ST_RDATA;
            end
          end
          ST_WDATA, ST_RDATA: if (bitcnt == 3'd7) addr <= addr + 1'b1;
          ST_WSR: if (bitcnt == 3'd7) begin
            if (sr_ok) begin
              srd_q <= sh_next[7];
              bp_q  <= sh_next[3:2];
            end
            state <= ST_DEAD;
          end
          ST_RID: if (bitcnt == 3'd7) begin
            idcnt <= idcnt + 2'd1;
            if (idcnt == 2'd2) state <= ST_DEAD;
          end
          default: ;
        endcase
      end else if (fall && out_st) begin
        so_q <= out_byte[~bitcnt];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= !csn_s && holdn_s && out_st;
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       csn_s,
  input logic       holdn_s,
  input logic       wpn_s,
  input logic       so_oe_o,
  input logic       wel_q,
  input logic       srd_q,
  input logic [1:0] bp_q,
  input logic       mem_we
);
  a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !so_oe_o);

  a_r11_oe_off_in_hold: assert property (@(posedge clk) disable iff (rst)
    !holdn_s |=> !so_oe_o);

  a_r8_write_needs_latch: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel_q);

  a_r9_hw_protect_holds: assert property (@(posedge clk) disable iff (rst)
    (srd_q && !wpn_s) |=> ($stable(bp_q) && srd_q));

  a_r7_status_changes_when_selected: assert property (@(posedge clk) disable iff (rst)
    !$stable({srd_q, bp_q}) |-> $past(!csn_s));

  a_r1_oe_known: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(so_oe_o));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst(rst), .csn_s(csn_s), .holdn_s(holdn_s), .wpn_s(wpn_s),
  .so_oe_o(so_oe_o), .wel_q(wel_q), .srd_q(srd_q), .bp_q(bp_q), .mem_we(mem_we)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
  logic clk = 0, rst = 1;
  logic sck = 0, si = 0, csn = 1, holdn = 1, wpn = 1;
  logic so, so_oe;
  int checks = 0, fails = 0;
  logic m3 = 0;
  logic oe_seen;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  localparam int H = 6;

  always #10 clk = ~clk;

  spi_mem_slave u0 (
    .clk(clk), .rst(rst), .sck_i(sck), .si_i(si), .csn_i(csn),
    .holdn_i(holdn), .wpn_i(wpn), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    sck = 0; si = b;
    half();
    r = so;
    oe_seen = oe_seen | so_oe;
    sck = 1;
    half();
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic tx_begin();
    sck = m3; half();
    csn = 0; half();
    oe_seen = 0;
  endtask

  task automatic tx_end();
    if (!m3) begin sck = 0; half(); end
    csn = 1; half(); half();
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    byte_x(b, d);
  endtask

  task automatic simple_op(input logic [7:0] op);
    tx_begin(); send(op); tx_end();
  endtask

  task automatic rdsr(output logic [7:0] v);
    tx_begin(); send(8'h05); byte_x(8'h00, v); tx_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    tx_begin(); send(8'h01); send(v); tx_end();
  endtask

  task automatic wr_bytes(input logic [23:0] a, input int n);
    tx_begin(); send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) send(wbuf[i]);
    chk("R1 oe during write", {7'd0, oe_seen}, 8'h00);
    tx_end();
  endtask

  task automatic rd_bytes(input logic [23:0] a, input int n);
    tx_begin(); send(8'h03); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    chk("R1 oe during address", {7'd0, oe_seen}, 8'h00);
    for (int i = 0; i < n; i++) byte_x(8'h00, rbuf[i]);
    tx_end();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe at reset", {7'd0, so_oe}, 8'h00);
    rdsr(v); chk("R7 status after reset", v, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    simple_op(8'h06); rdsr(v); chk("R7 latch set", v, 8'h02);
    simple_op(8'h04); rdsr(v); chk("R7 latch cleared", v, 8'h00);
  endtask

  task automatic t_burst();
    logic [7:0] v;
    m3 = 0;
    simple_op(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_bytes(24'h000100, 4);
    rdsr(v); chk("R7 latch cleared after write", v, 8'h00);
    simple_op(8'h06); wbuf[0] = 8'h42; wr_bytes(24'h000005, 1);
    m3 = 1;
    rd_bytes(24'h000100, 4);
    chk("R3 mode3 byte0", rbuf[0], 8'h11);
    chk("R4 burst byte1", rbuf[1], 8'h22);
    chk("R4 burst byte2", rbuf[2], 8'h33);
    chk("R4 burst byte3", rbuf[3], 8'h44);
    m3 = 0;
    rd_bytes(24'hFC0101, 1);
    chk("R4 upper address bits ignored", rbuf[0], 8'h22);
  endtask

  task automatic t_nolatch();
    wbuf[0] = 8'hEE; wr_bytes(24'h000100, 1);
    rd_bytes(24'h000100, 1);
    chk("R8 write without latch refused", rbuf[0], 8'h11);
  endtask

  task automatic t_wrap();
    simple_op(8'h06);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    wr_bytes(24'h03FFFE, 3);
    rd_bytes(24'h03FFFF, 2);
    chk("R5 read at top", rbuf[0], 8'hA2);
    chk("R5 read wraps to zero", rbuf[1], 8'hA3);
    rd_bytes(24'h000000, 1);
    chk("R5 write wrapped to zero", rbuf[0], 8'hA3);
  endtask

  task automatic t_partial();
    logic [7:0] d;
    simple_op(8'h06);
    tx_begin(); send(8'h02); send(8'h00); send(8'h01); send(8'h00);
    send(8'h55);
    for (int i = 0; i < 5; i++) bit_x(1'b0, d[i]);
    tx_end();
    rd_bytes(24'h000100, 2);
    chk("R10 full byte stored", rbuf[0], 8'h55);
    chk("R10 partial byte discarded", rbuf[1], 8'h22);
  endtask

  task automatic t_id();
    logic [7:0] a, b, c, d;
    tx_begin(); send(8'h9F);
    byte_x(8'h00, a); byte_x(8'h00, b); byte_x(8'h00, c);
    oe_seen = 0; byte_x(8'h00, d);
    chk("R6 oe after third byte", {7'd0, oe_seen}, 8'h00);
    tx_end();
    chk("R6 id byte0", a, 8'hAE);
    chk("R6 id byte1", b, 8'h83);
    chk("R6 id byte2", c, 8'h1A);
  endtask

  task automatic t_invalid();
    logic [7:0] v;
    tx_begin(); send(8'h9E); send(8'h06); send(8'h05); send(8'h00);
    chk("R2 oe after bad opcode", {7'd0, oe_seen}, 8'h00);
    tx_end();
    rdsr(v); chk("R2 bytes after bad opcode ignored", v, 8'h00);
  endtask

  task automatic t_prot();
    logic [7:0] v;
    simple_op(8'h06); wrsr(8'h04);
    rdsr(v); chk("R9 block protect 01 written", v, 8'h04);
    simple_op(8'h06); wbuf[0] = 8'h5C; wr_bytes(24'h02FF00, 1);
    simple_op(8'h06); wbuf[0] = 8'h6D; wr_bytes(24'h030005, 1);
    rd_bytes(24'h02FF00, 1); chk("R8 below protected range", rbuf[0], 8'h5C);
    rd_bytes(24'h030005, 1); chk("R8 protected upper quarter", rbuf[0], 8'h42);
    simple_op(8'h06); wrsr(8'h7F);
    rdsr(v); chk("R9 only bits 7,3,2 writable", v, 8'h0C);
    simple_op(8'h06); wbuf[0] = 8'h99; wr_bytes(24'h000100, 1);
    rd_bytes(24'h000100, 1); chk("R8 all protected", rbuf[0], 8'h55);
  endtask

  task automatic t_srd();
    logic [7:0] v;
    wpn = 1; simple_op(8'h06); wrsr(8'h80);
    rdsr(v); chk("R9 SRD set", v, 8'h80);
    wpn = 0; simple_op(8'h06); wrsr(8'h00);
    rdsr(v); chk("R9 hw protect refuses", v, 8'h80);
    wpn = 1; simple_op(8'h06); wrsr(8'h00);
    rdsr(v); chk("R9 pin high allows", v, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] a, b;
    logic r;
    m3 = 1;
    tx_begin(); send(8'h03); send(8'h00); send(8'h01); send(8'h00);
    for (int i = 7; i >= 5; i--) bit_x(1'b0, a[i]);
    holdn = 0; half();
    oe_seen = 0;
    for (int i = 0; i < 4; i++) bit_x(i[0], r);
    chk("R11 oe low in hold", {7'd0, oe_seen}, 8'h00);
    holdn = 1; half();
    for (int i = 4; i >= 0; i--) bit_x(1'b0, a[i]);
    byte_x(8'h00, b);
    tx_end();
    chk("R11 byte across hold", a, 8'h55);
    chk("R11 next byte after hold", b, 8'h22);
    m3 = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_burst();
    t_nolatch();
    t_wrap();
    t_partial();
    t_id();
    t_invalid();
    t_hold();
    t_prot();
    t_srd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule